// File: doc/BRIEF.md
# Configuration Packet Header Decoder

This block sits behind a word aligner and turns an already synchronized stream of 32-bit configuration words into register writes. Every packet opens with one header word. A short header names an operation, a target register and a small payload length; a long header carries only a large payload length and reuses the target of the most recent short header. The payload words that follow a write header each come out as one register write: a strobe, the target address and the data word.

Two targets are held inside the block. One is the frame address register and the other is the command register. Whenever the frame address register takes a new value, the block emits a one-cycle execute pulse that carries the command currently stored. Payload words aimed at the frame data target are also copied onto a streaming output. Header words with an unrecognised type are flagged through a sticky error bit and then dropped.

Top module: `cfgpkt_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is zero: no strobe, no stream word, no execute pulse, frame address and command cleared, error flag clear.
- R2: A short header with bits [31:29]=001, opcode [28:27]=10 (write), address [26:13] and count [10:0]=N>0 makes the next N accepted words into writes. Each write shows `wr_strobe`, that address and the word's data in the cycle after the word is accepted. The word after the last payload word is read as a header.
- R3: A header whose count is 0, including the no-operation word 0x20000000, produces no write. A run of such words produces none at all.
- R4: A long header with bits [31:29]=010 and count [26:0]=N>0 makes the next N accepted words into writes to the address of the most recent short header, provided that header was a write.
- R5: Short headers whose opcode is 00 (no-op) or 01 (read) take no payload, whatever their count field holds, and the word after them is read as a header.
- R6: Payload written to address 2 also appears on `fdata_valid`/`fdata_word`, in the same cycle as its write strobe. Writes to other addresses leave `fdata_valid` low.
- R7: A write to address 1 loads `frame_addr` and a write to address 4 loads `cmd_reg`, each in the cycle after the strobe. Writes to any other address change neither.
- R8: Each write to address 1 is followed one cycle later by a single-cycle `exec_pulse`, with `exec_cmd` equal to the command register value at that moment. Back-to-back frame address writes give back-to-back pulses.
- R9: A word read as a header whose bits [31:29] are neither 001 nor 010 sets `hdr_error`, which then stays set until reset. The word is discarded and the next word is read as a header.
- R10: A long header that arrives before any short header since reset sets `hdr_error` and is discarded with no write.
- R11: Cycles with `word_valid` low are ignored. They neither advance a payload count nor change any register, whatever `word_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| word_valid | input | 1 | Marks `word_data` as a stream word this cycle |
| word_data | input | 32 | Synchronized configuration word |
| wr_strobe | output | 1 | One register write this cycle |
| wr_addr | output | 14 | Target register of the write |
| wr_data | output | 32 | Data of the write |
| fdata_valid | output | 1 | Frame data word present on the stream port |
| fdata_word | output | 32 | Frame data word |
| frame_addr | output | 32 | Current frame address register |
| cmd_reg | output | 32 | Current command register |
| exec_pulse | output | 1 | Execute stored command (one cycle) |
| exec_cmd | output | 32 | Command carried by the execute pulse |
| hdr_error | output | 1 | Sticky malformed-header flag |

## Verification
The execute pulse from one frame address write can fall in the same cycle as the write strobe of the next payload word. That is also the cycle in which `frame_addr` is being reloaded. The bench provokes this with one write header of count 2 aimed at address 1, and with payload words sent on consecutive cycles. A behavioural reference model, compared on every clock, expects two adjacent pulses that both carry the unchanged command, and expects `frame_addr` to step through both values. The same overlap is repeated with idle gaps in the payload, so the pulses come out separated.

// File: rtl/cfgpkt_pkg.sv
// Shared encodings for the configuration packet decoder.
// Assumes the packet word layout is fixed at 32 bits.
package cfgpkt_pkg;
    localparam int WORD_W = 32;

    // Header type codes held in bits [31:29].
    localparam logic [2:0] HDR_SHORT = 3'b001;
    localparam logic [2:0] HDR_LONG  = 3'b010;

    // Bit position where the short-header address field starts.
    localparam int ADDR_LSB = 13;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSVD  = 2'b11
    } opcode_e;

    typedef enum logic {
        ST_HEADER  = 1'b0,
        ST_PAYLOAD = 1'b1
    } parse_state_e;
endpackage

// File: rtl/cfgpkt_parser.sv
// Header/payload parser. It reads each accepted word as either a header or a
// payload word. Write payloads are turned into registered write strobes, and
// frame data words are copied to a stream port.
// Assumes the input stream is already word-aligned and synchronized.
module cfgpkt_parser
    import cfgpkt_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int CNT1_W     = 11,
    parameter int CNT2_W     = 27,
    parameter int FDATA_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              fdata_valid,
    output logic [WORD_W-1:0] fdata_word,
    output logic              hdr_error
);
    localparam logic [ADDR_W-1:0] FDATA_SEL = ADDR_W'(FDATA_ADDR);
    localparam int                PAD_W     = CNT2_W - CNT1_W;

    parse_state_e      state;
    logic [CNT2_W-1:0] remaining;
    logic [ADDR_W-1:0] last_addr;
    opcode_e           last_op;
    logic              seen_short;

    logic [2:0]        f_type;
    opcode_e           f_op;
    logic [ADDR_W-1:0] f_addr;
    logic [CNT2_W-1:0] f_cnt_short;
    logic [CNT2_W-1:0] f_cnt_long;

    // Split the current word into header fields.
    always_comb begin
        f_type      = word_data[31:29];
        f_op        = opcode_e'(word_data[28:27]);
        f_addr      = word_data[ADDR_LSB +: ADDR_W];
        f_cnt_short = {{PAD_W{1'b0}}, word_data[CNT1_W-1:0]};
        f_cnt_long  = word_data[CNT2_W-1:0];
    end

    // Packet state machine: header decoding and payload counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HEADER;
            remaining  <= '0;
            last_addr  <= '0;
            last_op    <= OP_NOP;
            seen_short <= 1'b0;
            hdr_error  <= 1'b0;
        end else if (word_valid) begin
            if (state == ST_HEADER) begin
                case (f_type)
                    HDR_SHORT: begin
                        seen_short <= 1'b1;
                        last_addr  <= f_addr;
                        last_op    <= f_op;
                        if (f_op == OP_WRITE && f_cnt_short != '0) begin
                            remaining <= f_cnt_short;
                            state     <= ST_PAYLOAD;
                        end
                    end
                    HDR_LONG: begin
                        if (!seen_short) begin
                            hdr_error <= 1'b1;
                        end else if (last_op == OP_WRITE && f_cnt_long != '0) begin
                            remaining <= f_cnt_long;
                            state     <= ST_PAYLOAD;
                        end
                    end
                    default: hdr_error <= 1'b1;
                endcase
            end else begin
                remaining <= remaining - 1'b1;
                if (remaining == CNT2_W'(1)) begin
                    state <= ST_HEADER;
                end
            end
        end
    end

    // Register one write per accepted payload word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_strobe   <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            fdata_valid <= 1'b0;
            fdata_word  <= '0;
        end else begin
            wr_strobe   <= 1'b0;
            fdata_valid <= 1'b0;
            if (word_valid && state == ST_PAYLOAD) begin
                wr_strobe <= 1'b1;
                wr_addr   <= last_addr;
                wr_data   <= word_data;
                if (last_addr == FDATA_SEL) begin
                    fdata_valid <= 1'b1;
                    fdata_word  <= word_data;
                end
            end
        end
    end

    // A write strobe can only follow an accepted word.
    assert_strobe_needs_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(word_valid));

    // The stream port only carries words written to the frame data target.
    assert_stream_matches_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fdata_valid |-> (wr_strobe && wr_addr == FDATA_SEL && fdata_word == wr_data));

    // Once raised, the error flag holds until reset.
    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_error |=> hdr_error);

    // The payload counter never runs while it is at zero.
    assert_count_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAYLOAD) |-> (remaining != '0));
endmodule

// File: rtl/cfgpkt_regs.sv
// Frame address and command registers. A frame address load raises a
// one-cycle execute pulse in the following cycle, and the pulse carries the
// stored command. Assumes at most one write per cycle on the write bus.
module cfgpkt_regs
    import cfgpkt_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int FAR_ADDR = 1,
    parameter int CMD_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] frame_addr,
    output logic [WORD_W-1:0] cmd_reg,
    output logic              exec_pulse,
    output logic [WORD_W-1:0] exec_cmd
);
    localparam logic [ADDR_W-1:0] FAR_SEL = ADDR_W'(FAR_ADDR);
    localparam logic [ADDR_W-1:0] CMD_SEL = ADDR_W'(CMD_ADDR);

    logic far_hit;
    logic cmd_hit;

    // Decode which held register the current write targets.
    always_comb begin
        far_hit = wr_strobe && (wr_addr == FAR_SEL);
        cmd_hit = wr_strobe && (wr_addr == CMD_SEL);
    end

    // Load the held registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_addr <= '0;
            cmd_reg    <= '0;
        end else begin
            if (far_hit) frame_addr <= wr_data;
            if (cmd_hit) cmd_reg    <= wr_data;
        end
    end

    // Execute the stored command after each frame address load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_pulse <= 1'b0;
            exec_cmd   <= '0;
        end else begin
            exec_pulse <= far_hit;
            if (far_hit) exec_cmd <= cmd_reg;
        end
    end

    // The pulse always follows a frame address write one cycle earlier.
    assert_exec_after_far_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> $past(wr_strobe && wr_addr == FAR_SEL));

    // The pulse carries the command that is held when it fires.
    assert_exec_carries_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> (exec_cmd == cmd_reg));

    // Without a frame address write the frame address holds.
    assert_far_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && wr_addr == FAR_SEL) |=> $stable(frame_addr));

    // Without a command write the command holds.
    assert_cmd_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && wr_addr == CMD_SEL) |=> $stable(cmd_reg));
endmodule

// File: rtl/cfgpkt_decoder.sv
// Top of the configuration packet decoder. It joins the header/payload
// parser to the held-register bank. Assumes a synchronized 32-bit input.
module cfgpkt_decoder
    import cfgpkt_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int CNT1_W     = 11,
    parameter int CNT2_W     = 27,
    parameter int FAR_ADDR   = 1,
    parameter int FDATA_ADDR = 2,
    parameter int CMD_ADDR   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [31:0]       word_data,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              fdata_valid,
    output logic [31:0]       fdata_word,
    output logic [31:0]       frame_addr,
    output logic [31:0]       cmd_reg,
    output logic              exec_pulse,
    output logic [31:0]       exec_cmd,
    output logic              hdr_error
);
    cfgpkt_parser #(
        .ADDR_W(ADDR_W), .CNT1_W(CNT1_W), .CNT2_W(CNT2_W), .FDATA_ADDR(FDATA_ADDR)
    ) u_parser (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word_data(word_data),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .fdata_valid(fdata_valid), .fdata_word(fdata_word),
        .hdr_error(hdr_error)
    );

    cfgpkt_regs #(
        .ADDR_W(ADDR_W), .FAR_ADDR(FAR_ADDR), .CMD_ADDR(CMD_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_addr(frame_addr), .cmd_reg(cmd_reg),
        .exec_pulse(exec_pulse), .exec_cmd(exec_cmd)
    );
endmodule

// File: tb/cfgpkt_decoder_test.sv
// Bench: a behavioural reference model advanced on every rising edge and
// compared with the outputs on every falling edge, plus directed checks.
module cfgpkt_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        wr_strobe, fdata_valid, exec_pulse, hdr_error;
    logic [13:0] wr_addr;
    logic [31:0] wr_data, fdata_word, frame_addr, cmd_reg, exec_cmd;

    int errs = 0;
    int checks = 0;
    int wr_count = 0;
    int exec_count = 0;
    bit started = 0;
    bit finished = 0;
    string tag = "R1";

    // Reference model state.
    int          m_state = 0;
    int          m_rem = 0;
    int          m_addr = 0;
    int          m_op = 0;
    bit          m_seen = 0;
    bit          e_err = 0;
    bit          e_wr = 0;
    int          e_addr = 0;
    logic [31:0] e_data = '0;
    bit          e_fv = 0;
    logic [31:0] e_fw = '0;
    logic [31:0] e_far = '0;
    logic [31:0] e_cmd = '0;
    bit          e_exec = 0;
    logic [31:0] e_ecmd = '0;

    cfgpkt_decoder uut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .fdata_valid(fdata_valid), .fdata_word(fdata_word),
        .frame_addr(frame_addr), .cmd_reg(cmd_reg),
        .exec_pulse(exec_pulse), .exec_cmd(exec_cmd), .hdr_error(hdr_error)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] short_hdr(int op, int addr, int cnt);
        return {3'b001, 2'(op), 14'(addr), 2'b00, 11'(cnt)};
    endfunction

    function automatic logic [31:0] long_hdr(int cnt);
        return {3'b010, 2'b00, 27'(cnt)};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model, one step per rising edge.
    always @(posedge clk) begin
        bit          n_exec;
        logic [31:0] w;
        started = 1;
        if (!rst_n) begin
            m_state = 0; m_rem = 0; m_addr = 0; m_op = 0; m_seen = 0; e_err = 0;
            e_wr = 0; e_addr = 0; e_data = '0; e_fv = 0; e_fw = '0;
            e_far = '0; e_cmd = '0; e_exec = 0; e_ecmd = '0;
        end else begin
            n_exec = e_wr && e_addr == 1;
            if (n_exec) begin
                e_ecmd = e_cmd;
                e_far  = e_data;
                exec_count++;
            end
            if (e_wr && e_addr == 4) e_cmd = e_data;
            e_exec = n_exec;
            if (e_wr) wr_count++;
            e_wr = 0;
            e_fv = 0;
            if (word_valid) begin
                w = word_data;
                if (m_state == 1) begin
                    e_wr = 1; e_addr = m_addr; e_data = w;
                    if (m_addr == 2) begin e_fv = 1; e_fw = w; end
                    m_rem--;
                    if (m_rem == 0) m_state = 0;
                end else if (w[31:29] == 3'b001) begin
                    m_seen = 1; m_addr = int'(w[26:13]); m_op = int'(w[28:27]);
                    if (m_op == 2 && w[10:0] != 0) begin m_rem = int'(w[10:0]); m_state = 1; end
                end else if (w[31:29] == 3'b010) begin
                    if (!m_seen) e_err = 1;
                    else if (m_op == 2 && w[26:0] != 0) begin m_rem = int'(w[26:0]); m_state = 1; end
                end else begin
                    e_err = 1;
                end
            end
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            check({tag, "/R2"}, "wr_strobe", 32'(wr_strobe), 32'(e_wr));
            if (e_wr) begin
                check({tag, "/R2"}, "wr_addr", 32'(wr_addr), 32'(e_addr));
                check({tag, "/R2"}, "wr_data", wr_data, e_data);
            end
            check({tag, "/R6"}, "fdata_valid", 32'(fdata_valid), 32'(e_fv));
            if (e_fv) check({tag, "/R6"}, "fdata_word", fdata_word, e_fw);
            check({tag, "/R7"}, "frame_addr", frame_addr, e_far);
            check({tag, "/R7"}, "cmd_reg", cmd_reg, e_cmd);
            check({tag, "/R8"}, "exec_pulse", 32'(exec_pulse), 32'(e_exec));
            check({tag, "/R8"}, "exec_cmd", exec_cmd, e_ecmd);
            check({tag, "/R9"}, "hdr_error", 32'(hdr_error), 32'(e_err));
        end
    end

    task automatic send(logic [31:0] w);
        word_valid = 1'b1;
        word_data  = w;
        @(negedge clk);
        word_valid = 1'b0;
        word_data  = 32'hDEAD_BEEF;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        int base;
        @(negedge clk);
        idle(2);
        // R1: outputs cleared under reset.
        check("R1", "reset outputs", {wr_strobe, fdata_valid, exec_pulse, hdr_error},
              4'b0000);
        check("R1", "reset frame_addr", frame_addr, '0);
        rst_n = 1'b1;

        // R10: long header before any short header.
        tag = "R10";
        send(long_hdr(2));
        send(32'h1111_1111);
        idle(2);
        check("R10", "orphan long header flags error", 32'(hdr_error), 32'd1);
        do_reset();

        // R3: runs of no-op words, and a write with a zero count.
        tag = "R3";
        base = wr_count;
        for (int i = 0; i < 4; i++) send(32'h2000_0000);
        send(short_hdr(2, 1, 0));
        send(32'h2000_0000);
        idle(2);
        check("R3", "no writes from zero-count headers", 32'(wr_count - base), 32'd0);

        // R7/R2: command write using the 0x30008001 pattern, then a frame address write.
        tag = "R7";
        send(32'h3000_8001);
        send(32'h0000_000D);
        send(short_hdr(2, 1, 1));
        send(32'h0010_0000);
        idle(2);
        check("R7", "command loaded", cmd_reg, 32'h0000_000D);
        check("R8", "frame address loaded", frame_addr, 32'h0010_0000);

        // R8: two frame address words back to back (pulse overlaps next strobe).
        tag = "R8";
        base = exec_count;
        send(short_hdr(2, 1, 2));
        send(32'h0010_3400);
        send(32'h0014_0000);
        idle(3);
        check("R8", "one pulse per frame address write", 32'(exec_count - base), 32'd2);

        // R11: same burst with gaps and garbage on the data bus.
        tag = "R11";
        base = wr_count;
        send(short_hdr(2, 1, 2));
        idle(3);
        send(32'h0014_3400);
        idle(2);
        send(32'h0018_0000);
        idle(2);
        check("R11", "gaps do not consume payload", 32'(wr_count - base), 32'd2);

        // R6: frame data stream with a long header continuation (R4).
        tag = "R6";
        send(short_hdr(2, 2, 0));
        tag = "R4";
        base = wr_count;
        send(long_hdr(5));
        for (int i = 0; i < 5; i++) send(32'hF000_0000 + 32'(i));
        send(32'h2000_0000);
        idle(2);
        check("R4", "long header writes", 32'(wr_count - base), 32'd5);
        tag = "R6";
        send(short_hdr(2, 2, 3));
        send(32'hFFFF_FFFF);
        idle(1);
        send(32'hAA99_5566);
        send(32'h0000_00BB);
        idle(2);

        // R5: read and no-op headers with nonzero counts take no payload.
        tag = "R5";
        base = wr_count;
        send(short_hdr(1, 1, 5));
        send(32'h2000_0000);
        send(short_hdr(0, 4, 3));
        send(32'h2000_0000);
        send(long_hdr(4));
        send(32'h2000_0000);
        idle(2);
        check("R5", "read/nop take no payload", 32'(wr_count - base), 32'd0);
        check("R5", "no error", 32'(hdr_error), 32'd0);

        // R7: write to an unmapped address leaves held registers alone.
        tag = "R7";
        send(short_hdr(2, 7, 1));
        send(32'h1234_5678);
        idle(2);
        check("R7", "unmapped write keeps frame_addr", frame_addr, 32'h0018_0000);

        // R9: unknown type, word skipped, error sticky.
        tag = "R9";
        send(32'hE000_0000);
        send(short_hdr(2, 4, 1));
        send(32'h0000_0007);
        idle(3);
        check("R9", "error set", 32'(hdr_error), 32'd1);
        check("R9", "next word decoded as header", cmd_reg, 32'h0000_0007);
        idle(2);
        check("R9", "error stays set", 32'(hdr_error), 32'd1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20ns * 100000);
        finished = 1;
        checks++;
        errs++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule